// File: doc/BRIEF.md
# Byte-Scanned Count Snapshot Readout

This block keeps a 40-bit count snapshot and hands it out one byte at a time on an 8-bit bus, paced by an external scan strobe. A low level on the reset/load input captures the present count into the holding register and points the byte sequencer back at the least significant byte. Each falling scan edge moves the sequencer on by one byte. The bus is driven only while scan is high, so the host can use the shared bus for other traffic while scan is low.

Once every byte has been shown, the sequencer parks in a terminal position. There it blanks the bus and pulls its cascade output low. That output drives the enable of the next unit, so several units that share scan and reset/load take turns on one bus. The tri-state pads are modelled as a data bus with a separate output-enable flag. The bus is pushed by the scan strobe and has no ready signal, so there is no back-pressure. The host sets the pace and reads the byte while the enable flag is high.

Scan and reset/load are asynchronous. Each passes through a two-flop synchroniser on the system clock. The enable input is used directly, because in a chain it comes from the upstream unit's cascade output.

Top module: `bytescan_readout`

## Requirements
- R1: After system reset the sequencer points at byte position 1, `bus_oe` is 0, `cascade_n` is 1 and the snapshot holds zero, so a first scan without a load reads 0x00.
- R2: While `load_n` is low (held for at least three clock cycles), the snapshot copies `count_in` and the sequencer returns to position 1. The snapshot keeps the last value seen before `load_n` goes high.
- R3: With `enable_n` low, each falling edge of `scan` advances the sequencer by exactly one position. The new position takes effect on the third rising clock edge after the pin falls.
- R4: `bus_oe` is 1 exactly when `enable_n` is low, the synchronised scan is high and the sequencer is not in the terminal position. It rises on the second clock edge after `scan` rises and falls on the second edge after `scan` falls.
- R5: While `bus_oe` is 1, `bus_data` carries snapshot bits [8p-1:8(p-1)] for position p (1 to 5), least significant byte first. While `bus_oe` is 0, `bus_data` is 0x00.
- R6: A falling scan edge at position 5 moves the sequencer to the terminal position 6. There `cascade_n` is 0 and `bus_oe` is 0, and both stay so through further scan edges until the next load.
- R7: While `enable_n` is high, scan edges do not move the sequencer and `bus_oe` stays 0.
- R8: When a load and a scan falling edge reach the sequencer in the same cycle, the load wins: the position becomes 1 with no advance.
- R9: Changes on `count_in` between loads do not alter the bytes presented.
- R10: In a chain where a unit's `cascade_n` drives the next unit's `enable_n`, the downstream unit presents its bytes, starting from byte 1, on the scans that follow the upstream terminal edge. The two units never assert `bus_oe` together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| count_in | input | 40 | Count value captured on load |
| load_n | input | 1 | Active-low reset/load, asynchronous |
| scan | input | 1 | Scan strobe, asynchronous; falling edge advances |
| enable_n | input | 1 | Active-low unit enable |
| bus_data | output | 8 | Byte presented to the shared bus |
| bus_oe | output | 1 | Bus drive enable (tri-state control) |
| cascade_n | output | 1 | Low once the terminal position is reached |

## Verification
Each result has a fixed delay after its input changes. Scan level reaches `bus_oe` and `bus_data` two clock edges after the pin changes. A falling scan edge changes the position and `cascade_n` on the third edge. A load is held for three edges, and it is treated as complete three edges after release. The bench drives inputs on the falling clock edge and waits three full cycles after every change before it samples, again on a falling edge. This keeps each sample after the last register on its path has updated. The reference model steps its expected position at the same points in the stimulus.

// File: rtl/bytescan_pkg.sv
package bytescan_pkg;
  localparam int BS_NBYTES = 5;
  localparam int BS_BYTE_W = 8;
  localparam int BS_SYNC_STAGES = 2;

  function automatic int bs_pos_w(input int nbytes);
    return $clog2(nbytes + 2);
  endfunction
endpackage

// File: rtl/bytescan_sync.sv
module bytescan_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/bytescan_seq.sv
module bytescan_seq #(
  parameter int NBYTES = 5,
  parameter int PW     = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          step,
  input  logic          en,
  output logic [PW-1:0] pos,
  output logic          terminal
);
  localparam logic [PW-1:0] FIRST = PW'(1);
  localparam logic [PW-1:0] LAST  = PW'(NBYTES);

  logic live;
  // positions 0 and above LAST behave as the parked state
  assign live     = (pos >= FIRST) && (pos <= LAST);
  assign terminal = !live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pos <= FIRST;
    else if (restart)            pos <= FIRST;
    else if (step && en && live) pos <= pos + PW'(1);
  end
endmodule

// File: rtl/bytescan_latch.sv
module bytescan_latch #(
  parameter int NBYTES = 5,
  parameter int BYTE_W = 8,
  parameter int PW     = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     capture,
  input  logic [NBYTES*BYTE_W-1:0] count_in,
  input  logic [PW-1:0]            pos,
  output logic [NBYTES*BYTE_W-1:0] snap,
  output logic [BYTE_W-1:0]        byte_out
);
  logic [BYTE_W-1:0] lanes [NBYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       snap <= '0;
    else if (capture) snap <= count_in;
  end

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign lanes[g] = snap[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    byte_out = '0;
    for (int i = 0; i < NBYTES; i++) begin
      if (pos == PW'(i + 1)) byte_out = lanes[i];
    end
  end
endmodule

// File: rtl/bytescan_readout.sv
module bytescan_readout
  import bytescan_pkg::*;
#(
  parameter int NBYTES = BS_NBYTES,
  parameter int BYTE_W = BS_BYTE_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NBYTES*BYTE_W-1:0] count_in,
  input  logic                     load_n,
  input  logic                     scan,
  input  logic                     enable_n,
  output logic [BYTE_W-1:0]        bus_data,
  output logic                     bus_oe,
  output logic                     cascade_n
);
  localparam int PW = bs_pos_w(NBYTES);

  logic                     scan_s, scan_d, load_sn, fall;
  logic                     terminal;
  logic [PW-1:0]            pos;
  logic [NBYTES*BYTE_W-1:0] snap;
  logic [BYTE_W-1:0]        sel_byte;

  bytescan_sync #(.STAGES(BS_SYNC_STAGES), .RST_VAL(1'b0)) u_scan_sync (
    .clk(clk), .rst_n(rst_n), .d(scan), .q(scan_s)
  );

  bytescan_sync #(.STAGES(BS_SYNC_STAGES), .RST_VAL(1'b1)) u_load_sync (
    .clk(clk), .rst_n(rst_n), .d(load_n), .q(load_sn)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scan_d <= 1'b0;
    else        scan_d <= scan_s;
  end

  assign fall = scan_d & ~scan_s;

  bytescan_seq #(.NBYTES(NBYTES), .PW(PW)) u_seq (
    .clk(clk), .rst_n(rst_n), .restart(~load_sn), .step(fall),
    .en(~enable_n), .pos(pos), .terminal(terminal)
  );

  bytescan_latch #(.NBYTES(NBYTES), .BYTE_W(BYTE_W), .PW(PW)) u_latch (
    .clk(clk), .rst_n(rst_n), .capture(~load_sn), .count_in(count_in),
    .pos(pos), .snap(snap), .byte_out(sel_byte)
  );

  assign bus_oe    = ~enable_n & scan_s & ~terminal;
  assign bus_data  = bus_oe ? sel_byte : '0;
  assign cascade_n = ~terminal;
endmodule

// File: rtl/bytescan_readout_chk.sv
module bytescan_readout_chk #(
  parameter int NBYTES = 5,
  parameter int BYTE_W = 8,
  parameter int PW     = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     load_sn,
  input logic                     fall,
  input logic                     enable_n,
  input logic                     bus_oe,
  input logic                     cascade_n,
  input logic [PW-1:0]            pos,
  input logic [NBYTES*BYTE_W-1:0] snap,
  input logic [NBYTES*BYTE_W-1:0] count_in
);
  assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_sn |=> snap == $past(count_in));

  assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_sn |=> pos == PW'(1));

  assert_one_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_sn && fall && !enable_n && cascade_n) |=> pos == $past(pos) + PW'(1));

  assert_hold_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_sn && enable_n) |=> $stable(pos));

  assert_park_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cascade_n && load_sn) |=> (!cascade_n && !bus_oe));

  assert_oe_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> cascade_n);
endmodule

bind bytescan_readout bytescan_readout_chk #(
  .NBYTES(NBYTES), .BYTE_W(BYTE_W), .PW(PW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .load_sn(load_sn), .fall(fall),
  .enable_n(enable_n), .bus_oe(bus_oe), .cascade_n(cascade_n),
  .pos(pos), .snap(snap), .count_in(count_in)
);

// File: tb/bytescan_readout_tb.sv
module bytescan_readout_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scan = 1'b0;
  logic        load_n = 1'b1;
  logic        en_n = 1'b0;
  logic [39:0] cnt_a = '0, cnt_b = '0;
  logic [7:0]  bus_a, bus_b;
  logic        oe_a, oe_b, cas_a, cas_b;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [39:0] snap_a = '0, snap_b = '0;
  int pos_a = 1, pos_b = 1;

  always #10 clk = ~clk;

  bytescan_readout u_dut (
    .clk(clk), .rst_n(rst_n), .count_in(cnt_a), .load_n(load_n), .scan(scan),
    .enable_n(en_n), .bus_data(bus_a), .bus_oe(oe_a), .cascade_n(cas_a)
  );

  bytescan_readout u_nxt (
    .clk(clk), .rst_n(rst_n), .count_in(cnt_b), .load_n(load_n), .scan(scan),
    .enable_n(cas_a), .bus_data(bus_b), .bus_oe(oe_b), .cascade_n(cas_b)
  );

  function automatic logic [7:0] byte_of(input logic [39:0] v, input int p);
    return v[(p-1)*8 +: 8];
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait3();
    repeat (3) @(negedge clk);
  endtask

  task automatic do_load();
    load_n = 1'b0;
    snap_a = cnt_a;
    snap_b = cnt_b;
    wait3();
    load_n = 1'b1;
    wait3();
    pos_a = 1;
    pos_b = 1;
    check(cas_a == 1'b1, "R2", cas_a, 1);
    check(oe_a == 1'b0 && oe_b == 1'b0, "R2", {oe_a, oe_b}, 0);
  endtask

  task automatic pulse(input string dreq);
    bit exp_oe_a, exp_oe_b, en_b;
    scan = 1'b1;
    wait3();
    en_b = (pos_a > 5);
    exp_oe_a = !en_n && pos_a <= 5;
    exp_oe_b = en_b && pos_b <= 5;
    check(oe_a == exp_oe_a, en_n ? "R7" : "R4", oe_a, exp_oe_a);
    if (exp_oe_a) check(bus_a == byte_of(snap_a, pos_a), dreq, bus_a, byte_of(snap_a, pos_a));
    else          check(bus_a == 8'h00, "R5", bus_a, 0);
    check(oe_b == exp_oe_b, "R10", oe_b, exp_oe_b);
    if (exp_oe_b) check(bus_b == byte_of(snap_b, pos_b), "R10", bus_b, byte_of(snap_b, pos_b));
    check(!(oe_a && oe_b), "R10", {oe_a, oe_b}, 0);
    scan = 1'b0;
    wait3();
    if (!en_n && pos_a <= 5) pos_a++;
    if (en_b && pos_b <= 5) pos_b++;
    check(oe_a == 1'b0, "R4", oe_a, 0);
    check(cas_a == (pos_a <= 5), "R6", cas_a, (pos_a <= 5));
    check(cas_b == (pos_b <= 5), "R10", cas_b, (pos_b <= 5));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state, then one scan reads the zero snapshot
    check(oe_a == 1'b0 && cas_a == 1'b1, "R1", {oe_a, cas_a}, 1);
    pulse("R1");

    // R3/R5/R6: full sweep, then scans at the parked position
    cnt_a = 40'h55_44_33_22_11;
    cnt_b = 40'hAA_BB_CC_DD_EE;
    do_load();
    for (int i = 0; i < 5; i++) pulse("R3");
    check(cas_a == 1'b0, "R6", cas_a, 0);
    for (int i = 0; i < 6; i++) pulse("R6");
    check(cas_b == 1'b0, "R10", cas_b, 0);

    // R9: count changes after load are not seen
    cnt_a = 40'h12_34_56_78_9A;
    do_load();
    cnt_a = 40'hFF_FF_FF_FF_FF;
    for (int i = 0; i < 3; i++) pulse("R9");

    // R7: enable high freezes position
    en_n = 1'b1;
    pulse("R7");
    pulse("R7");
    en_n = 1'b0;
    pulse("R7");

    // R8: load arrives together with a scan fall
    cnt_a = 40'h0F_0E_0D_0C_0B;
    scan = 1'b1;
    wait3();
    scan = 1'b0;
    load_n = 1'b0;
    snap_a = cnt_a;
    snap_b = cnt_b;
    wait3();
    load_n = 1'b1;
    wait3();
    pos_a = 1;
    pos_b = 1;
    pulse("R8");
    pulse("R8");

    // constrained random rounds
    for (int r = 0; r < 30; r++) begin
      int n;
      cnt_a = {$urandom, $urandom} & 40'hFF_FFFF_FFFF;
      cnt_b = {$urandom, $urandom} & 40'hFF_FFFF_FFFF;
      do_load();
      n = $urandom_range(0, 12);
      for (int k = 0; k < n; k++) begin
        en_n = ($urandom_range(0, 3) == 0);
        pulse(en_n ? "R7" : "R5");
      end
      en_n = 1'b0;
      @(negedge clk);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule